// File: doc/BRIEF.md
# Pulse Accumulator with Overflow Interrupt

This block is an 8-bit accumulator for a single external input line. In event mode it adds one to its count on every selected edge of the input. In gated mode it adds one for every 64 internal clocks during which the input stays at its selected level. A two-flop synchroniser sits in front of both modes. The count can be read and written over a small register port at any time. Reset never clears it.

Two flags live in a status register, and each has its own enable in a mask register. The overflow flag is set when the count wraps to zero. The edge flag marks a counted edge in event mode, or the trailing edge of a gate in gated mode. Software clears a flag by writing a 1 to its bit. The interrupt line is high while any enabled flag is set. Bit positions that belong to neighbouring timer functions are kept as plain mask storage, or read as zero in the status register.

A state machine `pacc_ctrl` follows the mode inputs. It has four states: ST_OFF (accumulator disabled), ST_EVENT (edge counting), ST_GATE_IDLE (gated mode, input at its inactive level) and ST_GATE_OPEN (gated mode, input at its active level). Its transitions are:
- enable-to-event: ST_OFF to ST_EVENT.
- enable-to-gate: ST_OFF to ST_GATE_IDLE or ST_GATE_OPEN.
- mode-switch: ST_EVENT to either gate state, and back.
- gate-open: ST_GATE_IDLE to ST_GATE_OPEN.
- gate-close: ST_GATE_OPEN to ST_GATE_IDLE. This transition raises the edge flag.
- disable: any state to ST_OFF.

Top module: `pulse_accum`

## Requirements
- R1: Reset clears the mask register, both flags and `irq`. Reset leaves the count register holding its previous value.
- R2: In event mode, the input passes through two synchroniser flops. Each active edge then adds one to the count, modulo 256, three rising clock edges after the input changes. `act_pol`=1 selects rising edges and `act_pol`=0 selects falling edges. The opposite edge has no effect.
- R3: In gated mode, the count gains one for each 64 clocks during which the synchronised input sits at its active level. The active level is high when `act_pol`=1 and low when `act_pol`=0.
- R4: Edge flag (status bit 4). In event mode it is set by each active edge. In gated mode it is set only when the gate closes, and never while the gate is open.
- R5: Overflow flag (status bit 5). It is set when an increment takes the count from 0xFF to 0x00.
- R6: Status register (address 2). Writing 1 to bit 5 or bit 4 clears that flag, and writing 0 leaves it unchanged. If hardware sets a flag in the same cycle, the set wins. All other status bits read 0.
- R7: Mask register (address 1). Bits 7, 6, 5, 4, 1 and 0 are read/write storage; bits 3 and 2 read 0. Writing the mask never changes a flag.
- R8: `irq` is high exactly when (overflow flag and mask bit 5) or (edge flag and mask bit 4) is true.
- R9: Count register (address 0). It can be read or written at any time. A write that lands in the same cycle as an increment wins, and that increment then sets no overflow flag.
- R10: While `acc_en` is 0, nothing counts and the edge flag is not set.
- R11: A count read returns a copy taken at the falling clock edge. A read in the cycle after an increment therefore shows the old value before that falling edge and the new value after it. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Accumulator enable |
| gate_mode | input | 1 | 1 selects gated-time mode, 0 selects event mode |
| act_pol | input | 1 | Active edge or level select: 1 rising/high, 0 falling/low |
| pulse_in | input | 1 | Asynchronous external input |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register address: 0 count, 1 mask, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 when `bus_sel` is low |
| irq | output | 1 | Interrupt request |

## Verification
An input edge reaches the count on the third rising edge after the input is driven. The counted value is visible on `bus_rdata` only after the falling edge that follows. The bench therefore drives 2 ns after a rising edge and samples 7 ns after it, past the falling edge. Register writes take effect on the next rising edge. Flags and `irq` follow in that same cycle.

Gated counts are checked by holding the gate open for an exact multiple of 64 cycles. That yields a whole number of ticks whatever the phase of the tick counter. The collision case is timed cycle by cycle: the count write is placed on the very edge where the synchronised edge increments the count.

// File: rtl/pacc_pkg.sv
`timescale 1ns/1ps
package pacc_pkg;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_EVENT     = 2'd1,
        ST_GATE_IDLE = 2'd2,
        ST_GATE_OPEN = 2'd3
    } pacc_state_e;

    // register addresses
    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_MASK  = 2'd1;
    localparam logic [1:0] ADDR_FLAG  = 2'd2;

    // bit positions shared by mask and status
    localparam int OVF_BIT  = 5;
    localparam int EDGE_BIT = 4;

    // implemented read/write bits of the mask register
    localparam logic [7:0] MASK_RW = 8'hF3;

endpackage

// File: rtl/pacc_sync_edge.sv
`timescale 1ns/1ps
module pacc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;
    assign fall  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pacc_tick.sv
`timescale 1ns/1ps
module pacc_tick #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

endmodule

// File: rtl/pacc_ctrl.sv
`timescale 1ns/1ps
module pacc_ctrl
    import pacc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_en,
    input  logic gate_mode,
    input  logic act_pol,
    input  logic level,
    input  logic rise,
    input  logic fall,
    input  logic tick,
    output logic inc,
    output logic edge_evt
);
    pacc_state_e state_q, state_d;
    logic        lvl_act;
    logic        act_edge;

    assign lvl_act  = act_pol ? level : ~level;
    assign act_edge = act_pol ? rise  : fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!acc_en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (!gate_mode)   state_d = ST_EVENT;
                    else if (lvl_act) state_d = ST_GATE_OPEN;
                    else              state_d = ST_GATE_IDLE;
                end
                ST_EVENT: begin
                    if (gate_mode) state_d = lvl_act ? ST_GATE_OPEN : ST_GATE_IDLE;
                end
                ST_GATE_IDLE: begin
                    if (!gate_mode)   state_d = ST_EVENT;
                    else if (lvl_act) state_d = ST_GATE_OPEN;
                end
                ST_GATE_OPEN: begin
                    if (!gate_mode)    state_d = ST_EVENT;
                    else if (!lvl_act) state_d = ST_GATE_IDLE;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        inc      = 1'b0;
        edge_evt = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                inc      = 1'b0;
                edge_evt = 1'b0;
            end
            ST_EVENT: begin
                inc      = acc_en & ~gate_mode & act_edge;
                edge_evt = acc_en & ~gate_mode & act_edge;
            end
            ST_GATE_IDLE: begin
                inc      = 1'b0;
                edge_evt = 1'b0;
            end
            ST_GATE_OPEN: begin
                inc      = acc_en & gate_mode & tick;
                edge_evt = acc_en & gate_mode & ~lvl_act;
            end
            default: begin
                inc      = 1'b0;
                edge_evt = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pacc_regs.sv
`timescale 1ns/1ps
module pacc_regs
    import pacc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          inc,
    input  logic          edge_evt,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic [DW-1:0] cnt_val,
    output logic [DW-1:0] mask_val,
    output logic [DW-1:0] flag_val
);
    logic [DW-1:0] count_q;
    logic [DW-1:0] snap_q;
    logic [DW-1:0] mask_q;
    logic          ovf_q;
    logic          edgf_q;
    logic          wr_cnt, wr_mask, wr_flag;
    logic          wrap;
    logic          unused_bits;

    assign wr_cnt  = bus_sel & bus_wr & (bus_addr == ADDR_COUNT);
    assign wr_mask = bus_sel & bus_wr & (bus_addr == ADDR_MASK);
    assign wr_flag = bus_sel & bus_wr & (bus_addr == ADDR_FLAG);
    assign wrap    = inc & ~wr_cnt & (count_q == '1);

    // count: no reset on purpose
    always_ff @(posedge clk) begin
        if (wr_cnt)   count_q <= bus_wdata;
        else if (inc) count_q <= count_q + 1'b1;
    end

    // read copy taken half a cycle away from the update edge
    always_ff @(negedge clk) begin
        snap_q <= count_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= bus_wdata & DW'(MASK_RW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ovf_q <= 1'b0;
        else if (wrap)                       ovf_q <= 1'b1;
        else if (wr_flag && bus_wdata[OVF_BIT]) ovf_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           edgf_q <= 1'b0;
        else if (edge_evt)                    edgf_q <= 1'b1;
        else if (wr_flag && bus_wdata[EDGE_BIT]) edgf_q <= 1'b0;
    end

    always_comb begin
        flag_val           = '0;
        flag_val[OVF_BIT]  = ovf_q;
        flag_val[EDGE_BIT] = edgf_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                ADDR_COUNT: bus_rdata = snap_q;
                ADDR_MASK:  bus_rdata = mask_q;
                ADDR_FLAG:  bus_rdata = flag_val;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq      = (ovf_q & mask_q[OVF_BIT]) | (edgf_q & mask_q[EDGE_BIT]);
    assign cnt_val  = count_q;
    assign mask_val = mask_q;
    assign unused_bits = ^{bus_wdata[DW-1:6], bus_wdata[3:0]};

endmodule

// File: rtl/pulse_accum.sv
`timescale 1ns/1ps
module pulse_accum #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TICK_DIV    = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          gate_mode,
    input  logic          act_pol,
    input  logic          pulse_in,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    logic          lvl, rise, fall, tick;
    logic          inc_pulse, edge_evt;
    logic [DW-1:0] cnt_val, mask_val, flag_val;

    pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .level    (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    pacc_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pacc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .gate_mode (gate_mode),
        .act_pol   (act_pol),
        .level     (lvl),
        .rise      (rise),
        .fall      (fall),
        .tick      (tick),
        .inc       (inc_pulse),
        .edge_evt  (edge_evt)
    );

    pacc_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .inc       (inc_pulse),
        .edge_evt  (edge_evt),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .cnt_val   (cnt_val),
        .mask_val  (mask_val),
        .flag_val  (flag_val)
    );

endmodule

// File: rtl/pacc_checker.sv
`timescale 1ns/1ps
module pacc_checker
    import pacc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       acc_en,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       inc_pulse,
    input logic       edge_evt,
    input logic [7:0] cnt_val,
    input logic [7:0] mask_val,
    input logic [7:0] flag_val,
    input logic       irq
);
    logic wr_cnt, wr_mask, clr_ovf;
    assign wr_cnt  = bus_sel & bus_wr & (bus_addr == ADDR_COUNT);
    assign wr_mask = bus_sel & bus_wr & (bus_addr == ADDR_MASK);
    assign clr_ovf = bus_sel & bus_wr & (bus_addr == ADDR_FLAG) & bus_wdata[OVF_BIT];

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_val == 8'h00 && flag_val == 8'h00 && !irq));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_pulse && !wr_cnt) |=> (cnt_val == 8'($past(cnt_val) + 8'd1)));

    p_edge_flag_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_val[EDGE_BIT]) |-> $past(edge_evt));

    p_wrap_sets_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_pulse && !wr_cnt && cnt_val == 8'hFF) |=> flag_val[OVF_BIT]);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_val[OVF_BIT] && !clr_ovf) |=> flag_val[OVF_BIT]);

    p_mask_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && !inc_pulse && !edge_evt) |=> $stable(flag_val));

    p_irq_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_val[OVF_BIT] && mask_val[OVF_BIT]) |-> irq);

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_val == $past(bus_wdata)));

    p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (!inc_pulse && !edge_evt));

endmodule

bind pulse_accum pacc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .inc_pulse (inc_pulse),
    .edge_evt  (edge_evt),
    .cnt_val   (cnt_val),
    .mask_val  (mask_val),
    .flag_val  (flag_val),
    .irq       (irq)
);

// File: tb/pulse_accum_bench.sv
`timescale 1ns/1ps
module pulse_accum_bench;
    logic       clk = 1'b0;
    logic       rst_n, acc_en, gate_mode, act_pol, pulse_in;
    logic       bus_sel, bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] rd;

    always #5 clk = ~clk;

    pulse_accum u_pulse_accum (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .gate_mode(gate_mode),
        .act_pol(act_pol), .pulse_in(pulse_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {wr, addr, data, expected read}
    localparam int NV = 14;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 2'd0, 8'h5A, 8'h00},
        {1'b0, 2'd0, 8'h00, 8'h5A},
        {1'b1, 2'd1, 8'hFF, 8'h00},
        {1'b0, 2'd1, 8'h00, 8'hF3},
        {1'b1, 2'd1, 8'h24, 8'h00},
        {1'b0, 2'd1, 8'h00, 8'h20},
        {1'b1, 2'd1, 8'h13, 8'h00},
        {1'b0, 2'd1, 8'h00, 8'h13},
        {1'b0, 2'd2, 8'h00, 8'h00},
        {1'b1, 2'd2, 8'hFF, 8'h00},
        {1'b0, 2'd2, 8'h00, 8'h00},
        {1'b0, 2'd3, 8'h00, 8'h00},
        {1'b1, 2'd0, 8'hC3, 8'h00},
        {1'b0, 2'd0, 8'h00, 8'hC3}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #5 d = bus_rdata;
    endtask

    task automatic check_irq(input string req, input logic exp);
        @(posedge clk); #7;
        check(req, {7'd0, irq}, {7'd0, exp});
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2 pulse_in = act_pol;
            repeat (3) @(posedge clk);
            #2 pulse_in = ~act_pol;
            repeat (3) @(posedge clk);
        end
        repeat (2) @(posedge clk);
    endtask

    task automatic set_mode(input logic gm, input logic pol);
        @(posedge clk); #2 acc_en = 1'b0; gate_mode = gm; act_pol = pol; pulse_in = ~pol;
        repeat (5) @(posedge clk);
        #2 acc_en = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    task automatic gate_run(input int n, input string req);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2; pulse_in = act_pol;
        repeat (n) @(posedge clk);
        #1 check(req, bus_rdata, 8'h00);
        #1 pulse_in = ~act_pol;
        repeat (5) @(posedge clk);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_en = 1'b0; gate_mode = 1'b0; act_pol = 1'b1; pulse_in = 1'b0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        bus_read(2'd1, rd); check("R1 mask after reset", rd, 8'h00);
        bus_read(2'd2, rd); check("R1 status after reset", rd, 8'h00);
        check_irq("R1 irq after reset", 1'b0);

        // register table (R7 R9 R6 R11)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][18]) bus_write(VEC[i][17:16], VEC[i][15:8]);
            else begin
                bus_read(VEC[i][17:16], rd);
                check($sformatf("R7/R9/R6/R11 vector %0d", i), rd, VEC[i][7:0]);
            end
        end

        // R1 count survives reset
        bus_write(2'd0, 8'h77);
        @(posedge clk); #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        bus_read(2'd0, rd); check("R1 count kept over reset", rd, 8'h77);
        bus_read(2'd1, rd); check("R1 mask cleared by reset", rd, 8'h00);

        // R2 rising edges
        set_mode(1'b0, 1'b1);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd0, 8'h10);
        pulse(5);
        bus_read(2'd0, rd); check("R2 five rising edges", rd, 8'h15);
        bus_read(2'd2, rd); check("R4 edge flag in event mode", rd, 8'h10);
        // R11 read copy timing, R2 three-edge latency
        @(posedge clk); #2 pulse_in = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
        repeat (3) @(posedge clk);
        #2 check("R11 old value before falling edge", bus_rdata, 8'h15);
        #5 check("R11 new value after falling edge", bus_rdata, 8'h16);
        @(posedge clk); #2 pulse_in = 1'b0;
        repeat (4) @(posedge clk);
        bus_read(2'd0, rd); check("R2 inactive edge ignored", rd, 8'h16);

        // R2 falling edges
        set_mode(1'b0, 1'b0);
        bus_write(2'd0, 8'h20);
        pulse(3);
        bus_read(2'd0, rd); check("R2 falling edges counted", rd, 8'h23);

        // R5 R8 R6 R7 overflow and interrupt
        set_mode(1'b0, 1'b1);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'hFE);
        pulse(2);
        bus_read(2'd0, rd); check("R5 count wrapped", rd, 8'h00);
        bus_read(2'd2, rd); check("R5 overflow flag set", rd, 8'h30);
        check_irq("R8 irq low with enables off", 1'b0);
        bus_write(2'd1, 8'h20);
        bus_read(2'd2, rd); check("R7 mask write keeps flags", rd, 8'h30);
        check_irq("R8 irq from overflow", 1'b1);
        bus_write(2'd2, 8'h10);
        bus_read(2'd2, rd); check("R6 clear edge only", rd, 8'h20);
        check_irq("R8 irq still from overflow", 1'b1);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, rd); check("R6 writing zero keeps flag", rd, 8'h20);
        bus_write(2'd2, 8'h20);
        bus_read(2'd2, rd); check("R6 overflow cleared", rd, 8'h00);
        check_irq("R8 irq drops", 1'b0);
        bus_write(2'd1, 8'h10);
        pulse(1);
        check_irq("R8 irq from edge flag", 1'b1);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd1, 8'h00);

        // R9 write collides with increment
        bus_write(2'd0, 8'hFF);
        bus_write(2'd2, 8'hFF);
        @(posedge clk); #2 pulse_in = 1'b1;
        repeat (2) @(posedge clk);
        #2 bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h40;
        @(posedge clk); #2 bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(2'd0, rd); check("R9 write wins over increment", rd, 8'h40);
        bus_read(2'd2, rd); check("R9 no overflow on collision", rd, 8'h10);
        @(posedge clk); #2 pulse_in = 1'b0;
        repeat (4) @(posedge clk);

        // R10 disabled
        @(posedge clk); #2 acc_en = 1'b0;
        bus_write(2'd2, 8'hFF);
        bus_write(2'd0, 8'h33);
        pulse(3);
        bus_read(2'd0, rd); check("R10 no count when disabled", rd, 8'h33);
        bus_read(2'd2, rd); check("R10 no edge flag when disabled", rd, 8'h00);

        // R3 R4 gated, active high
        set_mode(1'b1, 1'b1);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd0, 8'h00);
        gate_run(128, "R4 no edge flag while gate open");
        bus_read(2'd0, rd); check("R3 two ticks in 128 cycles", rd, 8'h02);
        bus_read(2'd2, rd); check("R4 edge flag at gate close", rd, 8'h10);

        // R3 gated, active low
        set_mode(1'b1, 1'b0);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd0, 8'h10);
        gate_run(64, "R4 no edge flag while low gate open");
        bus_read(2'd0, rd); check("R3 one tick active low", rd, 8'h11);
        bus_read(2'd2, rd); check("R4 edge flag at low gate close", rd, 8'h10);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule